// File: doc/BRIEF.md
# DMA Request-to-Channel Mapper

This block connects a set of peripheral DMA request lines to a smaller set of DMA channels. Software fills one 8-bit map entry per request line. Each entry holds a channel number and a valid flag. The block brings every request level into the local clock domain and routes each synchronized level to its chosen channel. It also turns the request edges into per-channel status events for the transfer engines.

The map entries sit in two separate address windows. Requests 0 to 63 start at byte address 0x100, and the requests from 64 upward start at 0x1100. Both windows use one 32-bit word per entry. For each channel the block drives three outputs:
- a request-active level, which is the OR of all request lines mapped to that channel;
- a one-cycle pulse that sets the channel's request-after-stop status when a mapped request starts;
- a one-cycle pulse that sets the channel's end-of-receive status when a mapped request ends. The channel's status holder also uses this pulse to clear its request-after-stop bit.

A write that names a channel the block does not have raises an error pulse. Such a mapping routes the request nowhere.

Top module: `dreq_chan_map`

## Requirements
- R1: While reset is low and after it is released, every map entry reads 0, and `ch_active`, `ras_set`, `eor_set` and `cfg_err` are 0.
- R2: Request n, for n from 0 to 63, has its map entry at byte address 0x100 + 4·n. A write with `bus_wr` high stores `bus_wdata` as given at the next clock edge. `map_rdata` returns the stored byte in the same cycle as the address.
- R3: Request n, for n from 64 to NUM_REQ−1, has its map entry at byte address 0x1100 + 4·(n−64). Writing and reading behave as in R2.
- R4: An address that is outside both windows, or that has bits 1:0 not equal to zero, selects no entry. A write to it changes no entry, and a read of it returns 0.
- R5: In a map entry, bits 4:0 select the channel and bit 7 marks the entry valid. Bits 6:5 are stored but have no effect. A request whose entry has bit 7 clear has no effect on any channel output.
- R6: `ch_active[c]` is high when at least one request validly mapped to channel c is high. A change on a request input shows on `ch_active` after the third rising clock edge: two synchronizer stages and one output register.
- R7: A low-to-high change on a validly mapped request pulses `ras_set` for its channel. The pulse lasts exactly one cycle and appears in the same cycle that `ch_active` first shows the new level.
- R8: A high-to-low change on a validly mapped request pulses `eor_set` for its channel. The pulse lasts one cycle, with the same latency as R7.
- R9: A write to a map entry with bit 7 set and bits 4:0 at or above NUM_CH drives `cfg_err` high for the one cycle after that write's clock edge. The entry is still stored, and the request then drives no channel output.
- R10: When several requests map to one channel, `ch_active` is the OR of their levels. The edge pulses of any one of them reach that channel whatever the levels of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the map entry at `bus_addr` |
| bus_addr | input | ADDR_W | Byte address of a map entry |
| bus_wdata | input | 8 | Map entry value to write |
| map_rdata | output | 8 | Map entry at `bus_addr`, or 0 when no entry is selected |
| cfg_err | output | 1 | One-cycle flag for a valid mapping to a channel the block does not have |
| dreq | input | NUM_REQ | Request levels from the peripherals, asynchronous |
| ch_active | output | NUM_CH | Per-channel request-active level |
| ras_set | output | NUM_CH | Per-channel pulse on a mapped request rising |
| eor_set | output | NUM_CH | Per-channel pulse on a mapped request falling |

## Verification
The bench keeps the default 75 request lines, so it can reach the first and the last entry of the upper window and the address just past it. It sets NUM_CH to 20. With that setting, the 5-bit channel field can name channels 20 to 31, which do not exist. This makes the error flag and the route-nowhere behaviour reachable. It also tests requests whose entries are not valid, two requests sharing one channel, and the spare bits 6:5 being set.

// File: rtl/drm_pkg.sv
package drm_pkg;
    localparam int CH_W = 5;

    // One map entry: field positions are decoded by the router.
    typedef struct packed {
        logic            valid;   // bit 7
        logic [1:0]      spare;   // bits 6:5, stored only
        logic [CH_W-1:0] chan;    // bits 4:0
    } map_entry_t;

    localparam int ENTRY_W = $bits(map_entry_t);
endpackage

// File: rtl/drm_regs.sv
module drm_regs
    import drm_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 32,
    parameter int ADDR_W  = 16,
    parameter int LO_CNT  = 64,
    parameter int LO_BASE = 'h100,
    parameter int HI_BASE = 'h1100
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_wr,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [ENTRY_W-1:0]            bus_wdata,
    output logic [ENTRY_W-1:0]            rd_byte,
    output map_entry_t [NUM_REQ-1:0]      map_o,
    output logic                          err_o
);
    localparam int HI_CNT = NUM_REQ - LO_CNT;
    localparam int IDX_W  = $clog2(NUM_REQ);
    localparam logic [ADDR_W-1:0] LO_FIRST = ADDR_W'(LO_BASE);
    localparam logic [ADDR_W-1:0] LO_END   = ADDR_W'(LO_BASE + 4 * LO_CNT);
    localparam logic [ADDR_W-1:0] HI_FIRST = ADDR_W'(HI_BASE);
    localparam logic [ADDR_W-1:0] HI_END   = ADDR_W'(HI_BASE + 4 * HI_CNT);
    localparam logic [CH_W:0]     CH_LIM   = (CH_W + 1)'(NUM_CH);

    typedef struct packed {
        map_entry_t [NUM_REQ-1:0] map;
        logic                     err;
    } regs_t;

    regs_t st_d, st_q;

    logic              lo_hit, hi_hit, hit;
    logic [ADDR_W-1:0] lo_off, hi_off;
    logic [IDX_W-1:0]  idx;

    // Address decode: two windows, word aligned.
    always_comb begin
        lo_off = bus_addr - LO_FIRST;
        hi_off = bus_addr - HI_FIRST;
        lo_hit = (bus_addr[1:0] == 2'b00) && (bus_addr >= LO_FIRST) && (bus_addr < LO_END);
        hi_hit = (bus_addr[1:0] == 2'b00) && (bus_addr >= HI_FIRST) && (bus_addr < HI_END);
        hit    = lo_hit | hi_hit;
        if (hi_hit) begin
            idx = IDX_W'(hi_off >> 2) + IDX_W'(LO_CNT);
        end else begin
            idx = IDX_W'(lo_off >> 2);
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (bus_wr && hit) begin
            st_d.map[idx] = map_entry_t'(bus_wdata);
            st_d.err      = bus_wdata[ENTRY_W-1] &&
                            ({1'b0, bus_wdata[CH_W-1:0]} >= CH_LIM);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_byte = hit ? st_q.map[idx] : '0;
    assign map_o   = st_q.map;
    assign err_o   = st_q.err;
endmodule

// File: rtl/drm_sync.sv
module drm_sync #(
    parameter int W = 75
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1   = din;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.s2;
    assign rise_o  = st_q.s2 & ~st_q.prev;
    assign fall_o  = ~st_q.s2 & st_q.prev;
endmodule

// File: rtl/drm_route.sv
module drm_route
    import drm_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 32
) (
    input  map_entry_t [NUM_REQ-1:0] map_i,
    input  logic [NUM_REQ-1:0]       level_i,
    input  logic [NUM_REQ-1:0]       rise_i,
    input  logic [NUM_REQ-1:0]       fall_i,
    output logic [NUM_CH-1:0]        act_o,
    output logic [NUM_CH-1:0]        ras_o,
    output logic [NUM_CH-1:0]        eor_o
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic a, r, e;
        always_comb begin
            a = 1'b0;
            r = 1'b0;
            e = 1'b0;
            for (int q = 0; q < NUM_REQ; q++) begin
                if (map_i[q].valid && (map_i[q].chan == CH_W'(c))) begin
                    a = a | level_i[q];
                    r = r | rise_i[q];
                    e = e | fall_i[q];
                end
            end
        end
        assign act_o[c] = a;
        assign ras_o[c] = r;
        assign eor_o[c] = e;
    end
endmodule

// File: rtl/dreq_chan_map.sv
module dreq_chan_map
    import drm_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 32,
    parameter int ADDR_W  = 16,
    parameter int LO_CNT  = 64,
    parameter int LO_BASE = 'h100,
    parameter int HI_BASE = 'h1100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          map_rdata,
    output logic                cfg_err,
    input  logic [NUM_REQ-1:0]  dreq,
    output logic [NUM_CH-1:0]   ch_active,
    output logic [NUM_CH-1:0]   ras_set,
    output logic [NUM_CH-1:0]   eor_set
);
    map_entry_t [NUM_REQ-1:0] map;
    logic [NUM_REQ-1:0] lvl, rise, fall;
    logic [NUM_CH-1:0]  act_c, ras_c, eor_c;

    drm_regs #(
        .NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W),
        .LO_CNT(LO_CNT), .LO_BASE(LO_BASE), .HI_BASE(HI_BASE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rd_byte(map_rdata), .map_o(map), .err_o(cfg_err)
    );

    drm_sync #(.W(NUM_REQ)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(dreq),
        .level_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    drm_route #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_route (
        .map_i(map), .level_i(lvl), .rise_i(rise), .fall_i(fall),
        .act_o(act_c), .ras_o(ras_c), .eor_o(eor_c)
    );

    typedef struct packed {
        logic [NUM_CH-1:0] act;
        logic [NUM_CH-1:0] ras;
        logic [NUM_CH-1:0] eor;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d.act = act_c;
        out_d.ras = ras_c;
        out_d.eor = eor_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign ch_active = out_q.act;
    assign ras_set   = out_q.ras;
    assign eor_set   = out_q.eor;
endmodule

// File: rtl/drm_checker.sv
module drm_checker #(
    parameter int NUM_CH = 32,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        map_rdata,
    input logic              cfg_err,
    input logic [NUM_CH-1:0] ch_active,
    input logic [NUM_CH-1:0] ras_set,
    input logic [NUM_CH-1:0] eor_set
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (ch_active == '0 && ras_set == '0 && eor_set == '0 && !cfg_err)); // R1

    AST_UNALIGNED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1:0] != 2'b00) |-> (map_rdata == 8'h00)); // R4

    AST_RISE_SHOWS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((ras_set & ~ch_active) == '0)); // R7

    AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(bus_wr)); // R9
endmodule

bind dreq_chan_map drm_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_dreq_chan_map.sv
`timescale 1ns/1ps
module sim_dreq_chan_map;
    localparam int NREQ = 75;
    localparam int NCH  = 20;
    localparam int AW   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic            bus_wr = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [7:0]      bus_wdata = '0;
    logic [7:0]      map_rdata;
    logic            cfg_err;
    logic [NREQ-1:0] dreq = '0;
    logic [NCH-1:0]  ch_active, ras_set, eor_set;

    dreq_chan_map #(.NUM_REQ(NREQ), .NUM_CH(NCH), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .map_rdata(map_rdata), .cfg_err(cfg_err),
        .dreq(dreq), .ch_active(ch_active), .ras_set(ras_set), .eor_set(eor_set)
    );

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [7:0] model_map [NREQ];

    typedef struct {
        int          due;
        int          kind;   // 0 active, 1 rise pulse, 2 fall pulse, 3 error flag
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t sb[$];

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [NCH-1:0] route(logic [NREQ-1:0] v);
        logic [NCH-1:0] m;
        m = '0;
        for (int r = 0; r < NREQ; r++) begin
            if (model_map[r][7] && int'(model_map[r][4:0]) < NCH)
                m[model_map[r][4:0]] = m[model_map[r][4:0]] | v[r];
        end
        return m;
    endfunction

    function automatic int addr_of(int n);
        return (n < 64) ? ('h100 + 4 * n) : ('h1100 + 4 * (n - 64));
    endfunction

    // Monitor: compare due scoreboard items away from the active edge.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            item_t it;
            it = sb.pop_front();
            case (it.kind)
                0: chk(it.req, "ch_active", 32'(ch_active), it.exp);
                1: chk(it.req, "ras_set",   32'(ras_set),   it.exp);
                2: chk(it.req, "eor_set",   32'(eor_set),   it.exp);
                default: chk(it.req, "cfg_err", 32'(cfg_err), it.exp);
            endcase
        end
    end

    task automatic push(int due, int kind, logic [31:0] exp, string req);
        item_t it;
        it.due = due; it.kind = kind; it.exp = exp; it.req = req;
        sb.push_back(it);
    endtask

    // Driver: change request levels, push expected outputs three edges later.
    task automatic set_req(string req, logic [NREQ-1:0] nv);
        logic [NREQ-1:0] old;
        @(negedge clk);
        old = dreq;
        dreq = nv;
        push(cyc + 3, 0, 32'(route(nv)), req);
        push(cyc + 3, 1, 32'(route(nv & ~old)), req);
        push(cyc + 3, 2, 32'(route(~nv & old)), req);
        push(cyc + 4, 0, 32'(route(nv)), req);
        push(cyc + 4, 1, 32'h0, req);
        push(cyc + 4, 2, 32'h0, req);
        repeat (6) @(negedge clk);
    endtask

    task automatic wr_map(string req, int addr, logic [7:0] v, bit exp_err, int idx);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = AW'(addr);
        bus_wdata = v;
        push(cyc + 1, 3, 32'(exp_err), req);
        push(cyc + 2, 3, 32'h0, req);
        if (idx >= 0) model_map[idx] = v;
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic rd_chk(string req, int addr, logic [7:0] exp);
        @(negedge clk);
        bus_addr = AW'(addr);
        #1;
        chk(req, "map_rdata", 32'(map_rdata), 32'(exp));
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL R6 watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [NREQ-1:0] v;
        for (int i = 0; i < NREQ; i++) model_map[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        chk("R1", "ch_active", 32'(ch_active), 32'h0);
        chk("R1", "cfg_err", 32'(cfg_err), 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "ras_set", 32'(ras_set), 32'h0);
        chk("R1", "eor_set", 32'(eor_set), 32'h0);
        rd_chk("R1", addr_of(0), 8'h00);
        rd_chk("R1", addr_of(74), 8'h00);

        // R2: lower window
        wr_map("R2", addr_of(0), 8'h83, 1'b0, 0);
        rd_chk("R2", addr_of(0), 8'h83);
        wr_map("R2", addr_of(63), 8'h85, 1'b0, 63);
        rd_chk("R2", addr_of(63), 8'h85);
        // R3: upper window, first and last entries
        wr_map("R3", addr_of(64), 8'h87, 1'b0, 64);
        rd_chk("R3", 'h1100, 8'h87);
        wr_map("R3", addr_of(74), 8'h93, 1'b0, 74);
        rd_chk("R3", 'h1128, 8'h93);

        // R4: outside windows or unaligned
        wr_map("R4", 'h1000, 8'hFF, 1'b0, -1);
        rd_chk("R4", 'h1000, 8'h00);
        wr_map("R4", 'h112C, 8'h81, 1'b0, -1);
        rd_chk("R4", 'h112C, 8'h00);
        rd_chk("R4", addr_of(74), 8'h93);
        wr_map("R4", 'h101, 8'h99, 1'b0, -1);
        rd_chk("R4", 'h101, 8'h00);
        rd_chk("R4", addr_of(0), 8'h83);

        // R9: valid mapping to a channel beyond NCH; R5: invalid entry
        wr_map("R9", addr_of(5), 8'h94, 1'b1, 5);
        rd_chk("R9", addr_of(5), 8'h94);
        wr_map("R5", addr_of(6), 8'h13, 1'b0, 6);
        wr_map("R9", addr_of(7), 8'h93, 1'b0, 7);
        wr_map("R5", addr_of(2), 8'hE4, 1'b0, 2);
        rd_chk("R5", addr_of(2), 8'hE4);

        // R6 R7 R8: single request to channel 3
        v = '0; v[0] = 1'b1;
        set_req("R7", v);
        set_req("R8", '0);
        // R3 routing from the upper window
        v = '0; v[74] = 1'b1; v[64] = 1'b1;
        set_req("R6", v);
        set_req("R8", '0);
        // R5: invalid and unmapped requests; R9: mapped beyond NCH
        v = '0; v[6] = 1'b1; v[10] = 1'b1; v[5] = 1'b1;
        set_req("R5", v);
        chk("R5", "ch_active idle", 32'(ch_active), 32'h0);
        set_req("R9", '0);
        // R5: spare bits set still routes to channel 4
        v = '0; v[2] = 1'b1;
        set_req("R5", v);
        set_req("R5", '0);

        // R10: two requests sharing channel 3
        wr_map("R10", addr_of(1), 8'h83, 1'b0, 1);
        v = '0; v[0] = 1'b1;
        set_req("R10", v);
        v[1] = 1'b1;
        set_req("R10", v);
        v[0] = 1'b0;
        set_req("R10", v);
        set_req("R10", '0);

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule